// File: doc/BRIEF.md
# Priority-Resolved Bidirectional Shift Register

This block is a small storage register that can capture a parallel word, move its contents one place toward the least significant end, or move them one place toward the most significant end. Each of these actions has its own request line. The three lines may be raised together, so the block resolves them by a fixed priority: a parallel capture wins over a shift toward the LSB, and that shift wins over a shift toward the MSB. When no request is raised, the register keeps its value.

A small priority encoder turns the three requests into a two-bit internal select. The select drives a four-way multiplexer in front of every flip-flop, and the cells are generated from a width parameter. A shift toward the LSB takes its new top bit from one serial input. A shift toward the MSB takes its new bottom bit from a second serial input. All updates happen on the rising clock edge. A synchronous active-high reset clears the register.

Top module: `shreg_prio_bidir`

## Requirements
- R1: On a rising edge with `rst` high, the register becomes all zeros, whatever the request lines are doing.
- R2: With `rst` low and `req_load`, `req_right` and `req_left` all low, the register keeps its value, even when the parallel and serial inputs change.
- R3: With `rst` low and `req_load` high, the register takes `par_in` on the next edge, whatever `req_right` and `req_left` are.
- R4: With `rst` and `req_load` low and `req_right` high, bit i takes the old bit i+1, and the top bit takes `fill_top`, whatever `req_left` is.
- R5: With `rst`, `req_load` and `req_right` all low and `req_left` high, bit i takes the old bit i-1, and bit 0 takes `fill_bottom`.
- R6: The internal select is 2'b00 for hold, 2'b01 for parallel capture, 2'b10 for a shift toward the LSB and 2'b11 for a shift toward the MSB. It always names the operation the priority rule picks, so no request pattern leaves it undefined.
- R7: Starting from 4'b1001 with `fill_top` at 0, four shifts toward the LSB in a row give 4'b0100, 4'b0010, 4'b0001 and then 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| par_in | input | WIDTH | Parallel data to capture |
| req_load | input | 1 | Parallel capture request (highest priority) |
| req_right | input | 1 | Shift-toward-LSB request |
| req_left | input | 1 | Shift-toward-MSB request (lowest priority) |
| fill_top | input | 1 | Bit that enters the MSB on a shift toward the LSB |
| fill_bottom | input | 1 | Bit that enters bit 0 on a shift toward the MSB |
| q_out | output | WIDTH | Register contents |

## Verification
The checker compares the register on every edge with the value that the previous cycle's requests and inputs imply. It covers the clear, the hold, the capture and both shift directions. It also ties the internal select code to the request lines, so any slip in the priority order or the encoding is caught on the cycle it happens. Some things only the bench's scenarios can show: the fixed sequence of four shifts from 1001, that a changing parallel or serial input has no effect while holding, and that a clear wins over a capture request on the same edge.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        SEL_HOLD  = 2'b00,
        SEL_LOAD  = 2'b01,
        SEL_RIGHT = 2'b10,
        SEL_LEFT  = 2'b11
    } sel_e;

    typedef struct packed {
        logic load;
        logic right;
        logic left;
    } req_t;

    // Fixed priority: capture, then toward-LSB, then toward-MSB.
    function automatic sel_e pick_sel(input req_t r);
        sel_e s;
        if (r.load)       s = SEL_LOAD;
        else if (r.right) s = SEL_RIGHT;
        else if (r.left)  s = SEL_LEFT;
        else              s = SEL_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/shreg_sel_enc.sv
module shreg_sel_enc
    import shreg_pkg::*;
(
    input  req_t req,
    output sel_e sel
);

    always_comb begin
        sel = pick_sel(req);
    end

endmodule

// File: rtl/shreg_cell.sv
module shreg_cell
    import shreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sel_e sel,
    input  logic par_bit,
    input  logic from_upper,
    input  logic from_lower,
    output logic q_bit
);

    logic d_bit;

    always_comb begin
        case (sel)
            SEL_LOAD:  d_bit = par_bit;
            SEL_RIGHT: d_bit = from_upper;
            SEL_LEFT:  d_bit = from_lower;
            default:   d_bit = q_bit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q_bit <= 1'b0;
        else     q_bit <= d_bit;
    end

endmodule

// File: rtl/shreg_prio_bidir.sv
module shreg_prio_bidir
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] par_in,
    input  logic             req_load,
    input  logic             req_right,
    input  logic             req_left,
    input  logic             fill_top,
    input  logic             fill_bottom,
    output logic [WIDTH-1:0] q_out
);

    localparam int MSB = WIDTH - 1;

    req_t req;
    sel_e sel;
    logic [WIDTH-1:0] q_bits;

    assign req = '{load: req_load, right: req_right, left: req_left};

    shreg_sel_enc u_enc (
        .req (req),
        .sel (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic up_src;
        logic lo_src;
        if (i == MSB) begin : g_top
            assign up_src = fill_top;
        end else begin : g_mid_up
            assign up_src = q_bits[i+1];
        end
        if (i == 0) begin : g_bot
            assign lo_src = fill_bottom;
        end else begin : g_mid_lo
            assign lo_src = q_bits[i-1];
        end
        shreg_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .sel        (sel),
            .par_bit    (par_in[i]),
            .from_upper (up_src),
            .from_lower (lo_src),
            .q_bit      (q_bits[i])
        );
    end

    assign q_out = q_bits;

endmodule

// File: rtl/shreg_prio_chk.sv
module shreg_prio_chk
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] par_in,
    input logic             req_load,
    input logic             req_right,
    input logic             req_left,
    input logic             fill_top,
    input logic             fill_bottom,
    input logic [WIDTH-1:0] q_out,
    input sel_e             sel
);

    // R1
    assert_clear_R1: assert property (@(posedge clk)
        rst |=> (q_out == '0));

    // R2
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!req_load && !req_right && !req_left) |=> $stable(q_out));

    // R3
    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        req_load |=> (q_out == $past(par_in)));

    // R4
    assert_right_R4: assert property (@(posedge clk) disable iff (rst)
        (!req_load && req_right) |=>
            (q_out == {$past(fill_top), $past(q_out[WIDTH-1:1])}));

    // R5
    assert_left_R5: assert property (@(posedge clk) disable iff (rst)
        (!req_load && !req_right && req_left) |=>
            (q_out == {$past(q_out[WIDTH-2:0]), $past(fill_bottom)}));

    // R6
    assert_sel_load_R6: assert property (@(posedge clk) disable iff (rst)
        req_load |-> (sel == 2'b01));
    assert_sel_right_R6: assert property (@(posedge clk) disable iff (rst)
        (!req_load && req_right) |-> (sel == 2'b10));
    assert_sel_left_R6: assert property (@(posedge clk) disable iff (rst)
        (!req_load && !req_right && req_left) |-> (sel == 2'b11));
    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!req_load && !req_right && !req_left) |-> (sel == 2'b00));

endmodule

bind shreg_prio_bidir shreg_prio_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .par_in      (par_in),
    .req_load    (req_load),
    .req_right   (req_right),
    .req_left    (req_left),
    .fill_top    (fill_top),
    .fill_bottom (fill_bottom),
    .q_out       (q_out),
    .sel         (sel)
);

// File: tb/sim_shreg_prio_bidir.sv
`timescale 1ns/1ps
module sim_shreg_prio_bidir;

    localparam int W = 4;

    typedef struct packed {
        logic       ld;
        logic       rt;
        logic       lf;
        logic       ft;
        logic       fb;
        logic [3:0] par;
        logic [3:0] exp;
    } vec_t;

    // Walk starts from the cleared state (0000).
    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1001, 4'b1001}, // R3 capture
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0100}, // R7 step 1
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0010}, // R7 step 2
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0001}, // R7 step 3
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000}, // R7 step 4
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1010, 4'b1010}, // R3/R6 capture wins
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1111, 4'b1010}, // R2 hold
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b1101}, // R4/R6 right wins
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0110, 4'b1010}, // R5 left, fill 0
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0101}, // R5 left, fill 1
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000, 4'b0010}, // R4 right, fill 0
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b0101}, // R5 left, fill 1
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0011, 4'b0101}  // R2 hold
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] par_in;
    logic         req_load, req_right, req_left, fill_top, fill_bottom;
    logic [W-1:0] q_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    shreg_prio_bidir #(.WIDTH(W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .par_in      (par_in),
        .req_load    (req_load),
        .req_right   (req_right),
        .req_left    (req_left),
        .fill_top    (fill_top),
        .fill_bottom (fill_bottom),
        .q_out       (q_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q_out=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic rt, input logic lf,
                         input logic ft, input logic fb, input logic [W-1:0] p);
        @(negedge clk);
        req_load = ld; req_right = rt; req_left = lf;
        fill_top = ft; fill_bottom = fb; par_in = p;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; par_in = '0; req_load = 1'b0; req_right = 1'b0;
        req_left = 1'b0; fill_top = 1'b0; fill_bottom = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", q_out, 4'b0000);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].ld, TBL[k].rt, TBL[k].lf, TBL[k].ft, TBL[k].fb, TBL[k].par);
            check($sformatf("R2-R7 vector %0d", k), q_out, TBL[k].exp);
        end

        // R2: a long hold while the data inputs toggle
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 1'b0, 1'b0, k[0], ~k[0], 4'(k * 5));
        end
        check("R2 long hold", q_out, 4'b0101);

        // R5: four left shifts fill the register from the bottom with 1s
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000);
        end
        check("R5 four left shifts", q_out, 4'b1111);

        // R1: the clear wins over a capture request on the same edge
        @(negedge clk);
        rst = 1'b1; req_load = 1'b1; par_in = 4'b0110;
        @(posedge clk);
        #1;
        check("R1 clear beats capture", q_out, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R3 capture after clear", q_out, 4'b0110);

        // R4: the top bit fills from fill_top
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0000);
        check("R4 fill top", q_out, 4'b1011);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: q_out=%b expected=completion", q_out);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule